// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer

This block is a small timer peripheral with five down counters. Channels 0 to 3 each drive one pulse-width output. Channel 4 is a plain interval timer with no output pin, and software sees its progress through its live-count register. Software fills a count buffer and, on channels 0 to 3, a compare buffer. It then pulses that channel's load bit, which moves both buffers into the working registers. It then sets the run bit. Buffer writes made while a counter runs reach the counter only at the next reload or the next manual load.

Two 8-bit prescalers divide the system clock. The first feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. A 4-bit divider code on each channel divides the prescaled rate further. The result is a one-cycle count enable, not a derived clock. A channel's output sits at its idle level and goes active on the first decrement that lands exactly on the compare value. The output goes back to idle when the counter reloads. Access is through a plain register port: a write strobe with address and data, and read data that follows the address combinationally. There is no handshake because every access completes in one cycle.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads zero, every live count reads zero and all outputs are low.
- R2: Register map (5-bit address). 0x00 holds the prescalers: first in bits [7:0], second in [15:8]. 0x01 holds the divider codes, channel n in bits [4n+3:4n]. 0x02 is the control word, channel n in bits [4n+3:4n], bit 4n = run, 4n+1 = load, 4n+2 = invert, 4n+3 = auto-reload. 0x08+n is the count buffer (n = 0..4). 0x10+n is the compare buffer (n = 0..3). 0x18+n is the read-only live count. Unmapped addresses read zero.
- R3: While a channel's load bit is set, each clock copies the count buffer and compare buffer into the working registers and forces the output to idle. The counter does not step during that time.
- R4: With run set and load clear, the live count drops by exactly one per channel tick. With run clear, the live count holds.
- R5: The tick period in clocks is (prescaler + 1) × 2^code for codes 0 to 4. Codes above 4 divide by 16. Prescaler 0 times channels 0 and 1, and prescaler 1 times channels 2, 3 and 4.
- R6: A non-inverted output is low until a decrement leaves the count equal to the compare value. From that tick on, the output is high.
- R7: A compare value equal to the loaded count never drives the output high.
- R8: On a tick at count zero with auto-reload set, the counter reloads both buffers, returns the output to idle and keeps counting. With auto-reload clear, the count stays at zero and the output keeps its level.
- R9: Writing a buffer while the counter runs leaves the current count path unchanged until a reload or a manual load.
- R10: The invert bit flips the output polarity of channels 0 to 3. Channel 4 has no compare buffer and no invert bit: address 0x14 and control bit 18 read zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_wr | input | 1 | Write strobe; reg_wdata is stored at reg_addr on this edge |
| reg_addr | input | 5 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 4 | Pulse outputs of channels 0 to 3 |

## Verification
The bench aims at the compare test after a decrement. A design that tested compare before decrementing would raise the output one tick early, and it would fire when compare equals the loaded count. The bench times several divider codes over windows that are exact multiples of the expected period. A design with an off-by-one in the prescaler wrap, or with the wrong channel-to-prescaler grouping, therefore ends on the wrong live count. The bench also writes a buffer in the middle of a run. An implementation that is not double-buffered would jump to the new value instead of continuing from the old one. Finally, the bench follows an inverted channel through two reload periods, which exposes a reload that fails to clear the output.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NCH    = 5;
  localparam int NPWM   = 4;
  localparam int ADDR_W = 5;
  localparam int GRP_W  = 4;
  localparam int DSEL_W = 4;

  localparam int B_RUN  = 0;
  localparam int B_LOAD = 1;
  localparam int B_INV  = 2;
  localparam int B_ARL  = 3;

  localparam logic [1:0] BANK_CFG = 2'b00;
  localparam logic [1:0] BANK_CNT = 2'b01;
  localparam logic [1:0] BANK_CMP = 2'b10;
  localparam logic [1:0] BANK_OBS = 2'b11;

  localparam logic [2:0] IDX_PRESCALE = 3'd0;
  localparam logic [2:0] IDX_DIVSEL   = 3'd1;
  localparam logic [2:0] IDX_CTRL     = 3'd2;

  // low bits of the divide counter that must all be one for a tick
  function automatic logic [DSEL_W-1:0] div_mask(input logic [DSEL_W-1:0] code);
    case (code)
      4'd0:    div_mask = 4'b0000;
      4'd1:    div_mask = 4'b0001;
      4'd2:    div_mask = 4'b0011;
      4'd3:    div_mask = 4'b0111;
      default: div_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ps_val,
  output logic            ps_tick,
  output logic [3:0]      div_cnt
);
  logic [PS_W-1:0] ps_cnt;

  assign ps_tick = (ps_cnt == ps_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_cnt  <= '0;
      div_cnt <= '0;
    end else begin
      if (ps_cnt >= ps_val) ps_cnt <= '0;
      else                  ps_cnt <= ps_cnt + 1'b1;
      if (ps_tick) div_cnt <= div_cnt + 4'd1;
    end
  end

  assert_ps_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ps_tick |=> ps_cnt == '0);
  assert_div_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ps_tick |=> div_cnt == $past(div_cnt) + 4'd1);
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8,
  parameter int DW    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DW-1:0]                   wdata,
  output logic [DW-1:0]                   rdata,
  output logic [1:0][PS_W-1:0]            ps_val,
  output logic [NCH-1:0][DSEL_W-1:0]      div_sel,
  output logic [NCH-1:0]                  run,
  output logic [NCH-1:0]                  load,
  output logic [NCH-1:0]                  inv,
  output logic [NCH-1:0]                  arl,
  output logic [NCH-1:0][CNT_W-1:0]       cnt_buf,
  output logic [NPWM-1:0][CNT_W-1:0]      cmp_buf,
  input  logic [NCH-1:0][CNT_W-1:0]       live_cnt
);
  logic [1:0] bank;
  logic [2:0] idx;
  assign bank = addr[4:3];
  assign idx  = addr[2:0];

  logic unused_wbits;
  assign unused_wbits = ^wdata[DW-1:GRP_W*NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_val  <= '0;
      div_sel <= '0;
      run     <= '0;
      load    <= '0;
      inv     <= '0;
      arl     <= '0;
      cnt_buf <= '0;
      cmp_buf <= '0;
    end else if (wr) begin
      if (bank == BANK_CFG && idx == IDX_PRESCALE) begin
        ps_val[0] <= wdata[PS_W-1:0];
        ps_val[1] <= wdata[PS_W +: PS_W];
      end
      if (bank == BANK_CFG && idx == IDX_DIVSEL)
        for (int c = 0; c < NCH; c++) div_sel[c] <= wdata[DSEL_W*c +: DSEL_W];
      if (bank == BANK_CFG && idx == IDX_CTRL)
        for (int c = 0; c < NCH; c++) begin
          run[c]  <= wdata[GRP_W*c + B_RUN];
          load[c] <= wdata[GRP_W*c + B_LOAD];
          inv[c]  <= (c < NPWM) ? wdata[GRP_W*c + B_INV] : 1'b0;
          arl[c]  <= wdata[GRP_W*c + B_ARL];
        end
      if (bank == BANK_CNT)
        for (int c = 0; c < NCH; c++)
          if (idx == 3'(c)) cnt_buf[c] <= wdata[CNT_W-1:0];
      if (bank == BANK_CMP)
        for (int c = 0; c < NPWM; c++)
          if (idx == 3'(c)) cmp_buf[c] <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (bank)
      BANK_CFG: begin
        if (idx == IDX_PRESCALE) rdata[2*PS_W-1:0] = {ps_val[1], ps_val[0]};
        if (idx == IDX_DIVSEL)
          for (int c = 0; c < NCH; c++) rdata[DSEL_W*c +: DSEL_W] = div_sel[c];
        if (idx == IDX_CTRL)
          for (int c = 0; c < NCH; c++)
            rdata[GRP_W*c +: GRP_W] = {arl[c], inv[c], load[c], run[c]};
      end
      BANK_CNT: if (int'(idx) < NCH)  rdata[CNT_W-1:0] = cnt_buf[idx];
      BANK_CMP: if (int'(idx) < NPWM) rdata[CNT_W-1:0] = cmp_buf[idx[1:0]];
      default:  if (int'(idx) < NCH)  rdata[CNT_W-1:0] = live_cnt[idx];
    endcase
  end

  assert_no_ival_inv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !inv[NCH-1]);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W   = 16,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic             inv,
  input  logic             arl,
  input  logic [CNT_W-1:0] buf_cnt,
  input  logic [CNT_W-1:0] buf_cmp,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q, dec;
  logic             raw_q, step, at_zero, hit;

  assign step    = run && tick && !load;
  assign at_zero = (cnt_q == '0);
  assign dec     = cnt_q - 1'b1;
  assign hit     = HAS_CMP && (dec == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      raw_q <= 1'b0;
    end else if (load) begin
      cnt_q <= buf_cnt;
      cmp_q <= buf_cmp;
      raw_q <= 1'b0;
    end else if (step) begin
      if (at_zero) begin
        if (arl) begin
          cnt_q <= buf_cnt;
          cmp_q <= buf_cmp;
          raw_q <= 1'b0;
        end
      end else begin
        cnt_q <= dec;
        if (hit) raw_q <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = HAS_CMP ? (raw_q ^ inv) : 1'b0;

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(buf_cnt));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt_q));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_rise_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> cnt_q == cmp_q);
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && arl) |=> (cnt_q == $past(buf_cnt)) && !raw_q);
  assert_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && !arl) |=> at_zero && $stable(raw_q));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NPWM-1:0]   pwm_out
);
  logic [1:0][PS_W-1:0]         ps_val;
  logic [NCH-1:0][DSEL_W-1:0]   div_sel;
  logic [NCH-1:0]               run, load, inv, arl, ch_tick, ch_out;
  logic [NCH-1:0][CNT_W-1:0]    cnt_buf, live_cnt;
  logic [NPWM-1:0][CNT_W-1:0]   cmp_buf;
  logic [1:0]                   ps_tick;
  logic [1:0][3:0]              div_cnt;

  pwm_regs #(.CNT_W(CNT_W), .PS_W(PS_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ps_val(ps_val), .div_sel(div_sel),
    .run(run), .load(load), .inv(inv), .arl(arl),
    .cnt_buf(cnt_buf), .cmp_buf(cmp_buf), .live_cnt(live_cnt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ps
    pwm_prescale #(.PS_W(PS_W)) u_ps (
      .clk(clk), .rst_n(rst_n), .ps_val(ps_val[g]),
      .ps_tick(ps_tick[g]), .div_cnt(div_cnt[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int GRP = (c < 2) ? 0 : 1;
    logic [DSEL_W-1:0] msk;
    assign msk        = div_mask(div_sel[c]);
    assign ch_tick[c] = ps_tick[GRP] && ((div_cnt[GRP] & msk) == msk);

    if (c < NPWM) begin : g_pwm
      pwm_chan #(.CNT_W(CNT_W), .HAS_CMP(1'b1)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(ch_tick[c]), .run(run[c]),
        .load(load[c]), .inv(inv[c]), .arl(arl[c]),
        .buf_cnt(cnt_buf[c]), .buf_cmp(cmp_buf[c]),
        .cnt_o(live_cnt[c]), .out_o(ch_out[c])
      );
    end else begin : g_ival
      pwm_chan #(.CNT_W(CNT_W), .HAS_CMP(1'b0)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(ch_tick[c]), .run(run[c]),
        .load(load[c]), .inv(inv[c]), .arl(arl[c]),
        .buf_cnt(cnt_buf[c]), .buf_cmp('0),
        .cnt_o(live_cnt[c]), .out_o(ch_out[c])
      );
    end
  end

  assign pwm_out = ch_out[NPWM-1:0];

  logic unused_ival_out;
  assign unused_ival_out = ch_out[NCH-1];

  assert_tick_needs_ps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tick[NCH-1] |-> ps_tick[1]);
  assert_idle_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load[0] && !inv[0]) |=> !pwm_out[0]);
endmodule

// File: tb/pwm_timer_tb_top.sv
module pwm_timer_tb_top;
  localparam int A_PS = 0, A_DIV = 1, A_CTRL = 2, A_CB = 8, A_CMP = 16, A_OBS = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input int a, input int d);
    reg_addr = 5'(a); reg_wdata = 32'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 5'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic prime(input int ch, input int cnt, input int cmp);
    wr(A_CB + ch, cnt);
    if (ch < 4) wr(A_CMP + ch, cmp);
    wr(A_CTRL, 1 << (4*ch + 1));
  endtask

  task automatic t_reset();
    int v;
    rd(A_CTRL, v);     check("R1 control", v, 0);
    rd(A_PS, v);       check("R1 prescale", v, 0);
    rd(A_OBS + 0, v);  check("R1 live count", v, 0);
    check("R1 outputs", int'(pwm_out), 0);
    @(negedge clk);
  endtask

  task automatic t_map();
    int v;
    wr(A_PS, 32'h0302);    rd(A_PS, v);  check("R2 prescale readback", v, 32'h0302);
    @(negedge clk);
    wr(A_DIV, 32'h43210);  rd(A_DIV, v); check("R2 divider readback", v, 32'h43210);
    @(negedge clk);
    wr(A_CTRL, 32'hFFFFF); rd(A_CTRL, v); check("R10 ch4 invert bit reads zero", v, 32'hBFFFF);
    @(negedge clk);
    wr(A_CTRL, 0);
    wr(A_CMP + 4, 32'h55); rd(A_CMP + 4, v); check("R10 ch4 compare absent", v, 0);
    @(negedge clk);
    wr(A_CB + 4, 77);      rd(A_CB + 4, v);  check("R2 ch4 count buffer", v, 77);
    @(negedge clk);
    wr(A_PS, 0);
    wr(A_DIV, 0);
  endtask

  task automatic t_load_run();
    int v;
    wr(A_CB + 0, 10); wr(A_CMP + 0, 4);
    wr(A_CTRL, 32'h3);               // run and load together
    repeat (4) @(negedge clk);
    rd(A_OBS + 0, v); check("R3 load holds counter", v, 10);
    @(negedge clk);
    wr(A_CTRL, 0);
    wr(A_CB + 0, 20); wr(A_CTRL, 32'h2); wr(A_CTRL, 0);
    rd(A_OBS + 0, v); check("R3 manual load", v, 20);
    @(negedge clk);
    wr(A_CTRL, 32'h1);               // two ticks reach the counter
    wr(A_CB + 0, 99);
    wr(A_CTRL, 0);
    rd(A_OBS + 0, v); check("R4 R9 counted from old value", v, 18);
    repeat (5) @(negedge clk);
    rd(A_OBS + 0, v); check("R4 stopped counter holds", v, 18);
    @(negedge clk);
    wr(A_CTRL, 32'h2); wr(A_CTRL, 0);
    rd(A_OBS + 0, v); check("R9 new buffer after load", v, 99);
    @(negedge clk);
  endtask

  task automatic t_rate();
    int v;
    wr(A_PS, 32'h0100);
    wr(A_DIV, (7 << 16) | (1 << 8) | 2);
    wr(A_CB + 0, 1000); wr(A_CB + 2, 1000); wr(A_CB + 4, 1000);
    wr(A_CTRL, (1 << 1) | (1 << 9) | (1 << 17));
    wr(A_CTRL, 1 | (1 << 8) | (1 << 16));
    repeat (63) @(negedge clk);
    wr(A_CTRL, 0);                   // 64 clocks of running
    rd(A_OBS + 0, v); check("R5 ps0 div4", v, 984);
    rd(A_OBS + 2, v); check("R5 ps1 div2", v, 984);
    rd(A_OBS + 4, v); check("R5 code 7 acts as 16", v, 998);
    @(negedge clk);
    wr(A_PS, 0); wr(A_DIV, 0);
  endtask

  task automatic t_pwm_single();
    int v, e;
    prime(1, 8, 3);
    wr(A_CTRL, 32'h10);
    for (int j = 1; j <= 14; j++) begin
      e = (8 - (j - 1) < 0) ? 0 : 8 - (j - 1);
      rd(A_OBS + 1, v); check("R6 R8 count no reload", v, e);
      check("R6 output after match", int'(pwm_out[1]), (e <= 3) ? 1 : 0);
      @(negedge clk);
    end
    wr(A_CTRL, 0);
  endtask

  task automatic t_reload_inv();
    int v, e;
    prime(3, 4, 2);
    wr(A_CTRL, 32'hD000);            // run, invert, auto-reload on ch3
    for (int j = 1; j <= 16; j++) begin
      e = 4 - ((j - 1) % 5);
      rd(A_OBS + 3, v); check("R8 reload count", v, e);
      check("R10 R8 inverted output", int'(pwm_out[3]), (e <= 2) ? 0 : 1);
      @(negedge clk);
    end
    wr(A_CTRL, 0);
  endtask

  task automatic t_equal();
    int v;
    prime(2, 5, 5);
    wr(A_CTRL, 32'h900);
    for (int j = 1; j <= 20; j++) begin
      check("R7 compare equal count stays low", int'(pwm_out[2]), 0);
      @(negedge clk);
    end
    rd(A_OBS + 2, v); check("R7 counter kept running", v, 4 - (20 % 6) + 1);
    @(negedge clk);
    wr(A_CTRL, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_load_run();
    t_rate();
    t_pwm_single();
    t_reload_inv();
    t_equal();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule